// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block lets a clocked host read and write a byte-wide asynchronous static RAM of 2048 locations. The host raises a single-cycle request with a direction, an address and (for a write) a data byte while `ready` is high. The controller then produces the chip-enable, output-enable and write-enable pin sequence the memory needs, drives the data bus during the write strobe, and samples it at the end of a read. Read access, write-pulse width and post-write recovery are parameters counted in clock cycles.

The data bus is presented pad-side as three signals: an output value, an output enable and an input value. A tristate pad outside the block joins them into one bidirectional bus. A read drives the address together with chip-enable and output-enable in the same cycle. The access wait therefore counts from one common starting point, and no later-asserting strobe can stretch it.

A power-good input from an external supply monitor locks the memory out. While it is low, no cycle starts, every strobe stays inactive, the bus is released, and a new request ends at once with an error pulse. A read, or a write that has not yet begun its strobe, is abandoned when power-good drops. A write whose strobe is already low completes its full pulse and recovery.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is applied, and after it, chip-enable, output-enable and write-enable are high (1), the bus output enable is 0, `ready` is 1, and `rvalid` and `err` are 0.
- R2: A read request (req=1, wr=0) accepted in idle with power good drives chip-enable=0, output-enable=0 and write-enable=1 on the address given for exactly T_ACC cycles, starting the cycle after acceptance. `rvalid` is then 1 for one cycle, with `rdata` equal to the bus value sampled at the end of the last access cycle.
- R3: A write request (req=1, wr=1) accepted with power good produces, in order: one setup cycle (chip-enable=0, write-enable=1), T_WP cycles with chip-enable=0 and write-enable=0, one hold cycle (chip-enable=0, write-enable=1), then T_WR recovery cycles with all strobes high before idle. Write-enable never falls unless chip-enable was already low.
- R4: Output-enable stays high in every cycle of a write sequence, and output-enable is never low while write-enable is low.
- R5: While chip-enable is low, the memory address stays unchanged from cycle to cycle.
- R6: The bus output enable is 1 exactly in the cycles where write-enable is 0, and the bus output then carries the write data.
- R7: While power-good is 0 in idle, no strobe goes low, and a request produces `err`=1 for one cycle in the following cycle, with `ready` staying 1.
- R8: If power-good is 0 at the end of a read access cycle or of the write setup cycle, the cycle is abandoned: all strobes go high next cycle, `err` pulses once, and `rvalid` stays 0. `err` and `rvalid` are never 1 together.
- R9: A power-good drop while write-enable is low does not shorten the write: the pulse, hold and recovery run to full length with no `err`, and the data reaches memory.
- R10: `ready` is 0 in every non-idle cycle, and a request made while `ready` is 0 is ignored.
- R11: Data written to an address, including addresses 0 and 2047, is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good | input | 1 | Supply monitor status, 1 = normal operation allowed |
| req | input | 1 | Request strobe, sampled while ready is 1 |
| wr | input | 1 | Request direction, 1 = write |
| addr | input | 11 | Request address |
| wdata | input | 8 | Write data |
| ready | output | 1 | Controller idle and able to accept a request |
| rvalid | output | 1 | One-cycle pulse: rdata holds a completed read |
| rdata | output | 8 | Read data |
| err | output | 1 | One-cycle pulse: request refused or abandoned for power loss |
| sram_addr | output | 11 | Memory address pins |
| sram_ce_n | output | 1 | Memory chip-enable, active low |
| sram_oe_n | output | 1 | Memory output-enable, active low |
| sram_we_n | output | 1 | Memory write-enable, active low |
| sram_dq_o | output | 8 | Data bus value driven by the controller |
| sram_dq_oe | output | 1 | Data bus driver enable |
| sram_dq_i | input | 8 | Data bus value seen at the pad |

## Verification
The collision that matters is a power-good drop landing in the same cycle as a cycle in progress: a read access ending, a write setup finishing, or a write strobe in flight. The bench lowers power-good at the falling edge inside each of those phases, and once in idle in the same cycle as a request. A queue-based reference predicts, per cycle, whether the controller must abandon with an error, complete the pulse, or refuse. Follow-up reads show whether the aborted write left memory untouched and the in-flight write landed. The memory model returns unknown data until T_ACC cycles of active read have passed, so early sampling is caught.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_READ_WAIT = 3'd1,
    ST_WR_SETUP  = 3'd2,
    ST_WR_PULSE  = 3'd3,
    ST_WR_HOLD   = 3'd4,
    ST_RECOVER   = 3'd5
  } ctrl_state_e;

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/sram_ctrl_rst_sync.sv
module sram_ctrl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || !expired;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (!expired) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int T_ACC = 3,
  parameter int T_WP  = 2,
  parameter int T_WR  = 2,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          req,
  input  logic          wr,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          read_done,
  output logic          fail_evt,
  output ctrl_state_e   state,
  output logic          ready,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n
);

  localparam logic [CW-1:0] ACC_LD = CW'(T_ACC - 1);
  localparam logic [CW-1:0] WP_LD  = CW'(T_WP - 1);
  localparam logic [CW-1:0] WR_LD  = CW'(T_WR - 1);

  ctrl_state_e state_q;
  ctrl_state_e state_d;

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    accept    = 1'b0;
    read_done = 1'b0;
    fail_evt  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          if (!pwr_good) begin
            fail_evt = 1'b1;
          end else begin
            accept   = 1'b1;
            tmr_load = 1'b1;
            if (wr) begin
              state_d = ST_WR_SETUP;
            end else begin
              state_d = ST_READ_WAIT;
              tmr_val = ACC_LD;
            end
          end
        end
      end
      ST_READ_WAIT: begin
        if (!pwr_good) begin
          fail_evt = 1'b1;
          state_d  = ST_IDLE;
        end else if (tmr_expired) begin
          read_done = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      ST_WR_SETUP: begin
        if (!pwr_good) begin
          fail_evt = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          tmr_load = 1'b1;
          tmr_val  = WP_LD;
          state_d  = ST_WR_PULSE;
        end
      end
      ST_WR_PULSE: begin
        if (tmr_expired) begin
          state_d = ST_WR_HOLD;
        end
      end
      ST_WR_HOLD: begin
        tmr_load = 1'b1;
        tmr_val  = WR_LD;
        state_d  = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (tmr_expired) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;
  assign ready = (state_q == ST_IDLE);
  assign ce_n  = !((state_q == ST_READ_WAIT) || (state_q == ST_WR_SETUP) ||
                   (state_q == ST_WR_PULSE)  || (state_q == ST_WR_HOLD));
  assign oe_n  = (state_q != ST_READ_WAIT);
  assign we_n  = (state_q != ST_WR_PULSE);

  // A write strobe only falls inside an already-open chip-enable window
  AST_WE_AFTER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(!ce_n)) else $error("write strobe opened chip select"); // R3

  // Leaving the strobe phase always passes through one hold cycle with CE still low
  AST_HOLD_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> !ce_n) else $error("chip select released with write strobe"); // R3

  // No new cycle is launched from idle while power is bad
  AST_LOCKOUT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !pwr_good) |=> (ce_n && oe_n && we_n)) else $error("cycle started under lockout"); // R7

  // A strobe phase runs to completion once begun, even without power
  AST_PULSE_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !tmr_expired) |=> !we_n) else $error("write pulse shortened"); // R9

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          read_done,
  input  logic          fail_evt,
  input  ctrl_state_e   state,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] dq_out,
  output logic          dq_drive,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          err
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;
  logic [DW-1:0] rdat_q;
  logic          rvalid_q;
  logic          err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (accept) begin
      addr_q <= addr_in;
      wdat_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
    end else if (read_done) begin
      rdat_q <= dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= read_done;
      err_q    <= fail_evt;
    end
  end

  assign mem_addr = addr_q;
  assign dq_out   = wdat_q;
  assign dq_drive = (state == ST_WR_PULSE);
  assign rdata    = rdat_q;
  assign rvalid   = rvalid_q;
  assign err      = err_q;

  // A completed read is reported for a single cycle only
  AST_RVALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid) else $error("rvalid longer than one cycle"); // R2

  // Abort and completion are mutually exclusive
  AST_ERR_NOT_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && rvalid)) else $error("err and rvalid together"); // R8

  // Outgoing write data does not move while it is being driven
  AST_WDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |=> (!dq_drive || $stable(dq_out))) else $error("bus data changed mid-strobe"); // R6

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW    = 11,
  parameter int DW    = 8,
  parameter int T_ACC = 3,
  parameter int T_WP  = 2,
  parameter int T_WR  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_i
);

  localparam int TMAX = max_of3(T_ACC, T_WP, T_WR);
  localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX);

  logic          rst_sync_n;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;
  logic          accept;
  logic          read_done;
  logic          fail_evt;
  ctrl_state_e   state;

  sram_ctrl_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  sram_ctrl_timer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  sram_ctrl_fsm #(
    .T_ACC(T_ACC), .T_WP(T_WP), .T_WR(T_WR), .CW(CW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pwr_good   (pwr_good),
    .req        (req),
    .wr         (wr),
    .tmr_expired(tmr_expired),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .accept     (accept),
    .read_done  (read_done),
    .fail_evt   (fail_evt),
    .state      (state),
    .ready      (ready),
    .ce_n       (sram_ce_n),
    .oe_n       (sram_oe_n),
    .we_n       (sram_we_n)
  );

  sram_ctrl_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .accept   (accept),
    .read_done(read_done),
    .fail_evt (fail_evt),
    .state    (state),
    .addr_in  (addr),
    .wdata_in (wdata),
    .dq_in    (sram_dq_i),
    .mem_addr (sram_addr),
    .dq_out   (sram_dq_o),
    .dq_drive (sram_dq_oe),
    .rdata    (rdata),
    .rvalid   (rvalid),
    .err      (err)
  );

  // Output-enable is off whenever the write strobe is on
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sram_we_n |-> sram_oe_n) else $error("read and write strobes overlap"); // R4

  // Address is frozen for as long as the chip is selected
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sram_ce_n |=> (sram_ce_n || $stable(sram_addr))) else $error("address moved under chip select"); // R5

  // The bus is driven only inside the write strobe, and always inside it
  AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sram_dq_oe == !sram_we_n) else $error("bus drive outside strobe window"); // R6

  // Busy controller never reports ready
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sram_ce_n |-> !ready) else $error("ready while chip selected"); // R10

endmodule

// File: tb/tb_sram_cycle_ctrl.sv
module tb_sram_cycle_ctrl;

  localparam int AW    = 11;
  localparam int DW    = 8;
  localparam int T_ACC = 3;
  localparam int T_WP  = 2;
  localparam int T_WR  = 2;
  localparam int DEPTH = 1 << AW;

  localparam int K_READ  = 0;
  localparam int K_SETUP = 1;
  localparam int K_PULSE = 2;
  localparam int K_HOLD  = 3;
  localparam int K_REC   = 4;

  typedef struct {
    int            kind;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    bit            last;
  } ent_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pwr_good;
  logic          req;
  logic          wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          ready;
  logic          rvalid;
  logic [DW-1:0] rdata;
  logic          err;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n;
  logic          sram_oe_n;
  logic          sram_we_n;
  logic [DW-1:0] sram_dq_o;
  logic          sram_dq_oe;
  logic [DW-1:0] sram_dq_i;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  ent_t          q[$];
  logic [DW-1:0] model_mem [DEPTH];
  logic [DW-1:0] phys_mem  [DEPTH];
  int            rd_age = 0;
  bit            exp_rv = 0;
  bit            exp_err = 0;
  logic [DW-1:0] exp_rd = '0;
  string         err_tag = "R7";
  bit            run_checks = 0;

  always #10 clk = ~clk;

  sram_cycle_ctrl #(
    .AW(AW), .DW(DW), .T_ACC(T_ACC), .T_WP(T_WP), .T_WR(T_WR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .req(req), .wr(wr),
    .addr(addr), .wdata(wdata), .ready(ready), .rvalid(rvalid),
    .rdata(rdata), .err(err), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Memory model on the pins: returns unknown data until the access time has elapsed
  assign sram_dq_i = (!sram_ce_n && !sram_oe_n && sram_we_n && rd_age >= T_ACC)
                     ? phys_mem[sram_addr] : 'x;

  always @(negedge clk) begin
    if (!sram_ce_n && !sram_we_n && sram_dq_oe) phys_mem[sram_addr] = sram_dq_o;
    if (!sram_ce_n && !sram_oe_n && sram_we_n) rd_age = rd_age + 1;
    else rd_age = 0;
  end

  // Reference model: advances at the clock edge
  always @(posedge clk) begin
    cyc++;
    exp_rv  = 0;
    exp_err = 0;
    if (!rst_n) begin
      q.delete();
    end else if (q.size() != 0) begin
      if ((q[0].kind == K_READ || q[0].kind == K_SETUP) && !pwr_good) begin
        q.delete();
        exp_err = 1;
        err_tag = "R8";
      end else begin
        if (q[0].kind == K_PULSE) model_mem[q[0].a] = q[0].d;
        if (q[0].kind == K_READ && q[0].last) begin
          exp_rv = 1;
          exp_rd = model_mem[q[0].a];
        end
        void'(q.pop_front());
      end
    end else if (req) begin
      if (!pwr_good) begin
        exp_err = 1;
        err_tag = "R7";
      end else if (!wr) begin
        for (int i = 0; i < T_ACC; i++) q.push_back('{K_READ, addr, wdata, i == T_ACC - 1});
      end else begin
        q.push_back('{K_SETUP, addr, wdata, 1'b0});
        for (int i = 0; i < T_WP; i++) q.push_back('{K_PULSE, addr, wdata, i == T_WP - 1});
        q.push_back('{K_HOLD, addr, wdata, 1'b0});
        for (int i = 0; i < T_WR; i++) q.push_back('{K_REC, addr, wdata, i == T_WR - 1});
      end
    end
  end

  // Comparison away from the active edge
  always @(negedge clk) begin
    if (run_checks) begin
      logic [2:0] exp_pins;
      logic       exp_oe;
      logic       exp_ready;
      string      tag;
      exp_pins  = 3'b111;
      exp_oe    = 1'b0;
      exp_ready = 1'b1;
      tag       = pwr_good ? "R1" : "R7";
      if (q.size() != 0) begin
        exp_ready = 1'b0;
        case (q[0].kind)
          K_READ:  begin exp_pins = 3'b001; tag = "R2"; end
          K_SETUP: begin exp_pins = 3'b011; tag = "R3"; end
          K_PULSE: begin exp_pins = 3'b010; exp_oe = 1'b1; tag = pwr_good ? "R3" : "R9"; end
          K_HOLD:  begin exp_pins = 3'b011; tag = pwr_good ? "R3" : "R9"; end
          default: begin exp_pins = 3'b111; tag = pwr_good ? "R3" : "R9"; end
        endcase
        if (q[0].kind != K_REC)
          chk(sram_addr === q[0].a, "R5", "sram_addr", 32'(sram_addr), 32'(q[0].a));
        if (q[0].kind == K_SETUP || q[0].kind == K_PULSE || q[0].kind == K_HOLD)
          chk(sram_oe_n === 1'b1, "R4", "oe_n in write", 32'(sram_oe_n), 32'd1);
        if (q[0].kind == K_PULSE)
          chk(sram_dq_o === q[0].d, "R6", "bus data", 32'(sram_dq_o), 32'(q[0].d));
      end
      chk({sram_ce_n, sram_oe_n, sram_we_n} === exp_pins, tag, "ce/oe/we",
          32'({sram_ce_n, sram_oe_n, sram_we_n}), 32'(exp_pins));
      chk(sram_dq_oe === exp_oe, "R6", "dq_oe", 32'(sram_dq_oe), 32'(exp_oe));
      chk(ready === exp_ready, "R10", "ready", 32'(ready), 32'(exp_ready));
      chk(rvalid === exp_rv, "R2", "rvalid", 32'(rvalid), 32'(exp_rv));
      chk(err === exp_err, err_tag, "err", 32'(err), 32'(exp_err));
      if (exp_rv)
        chk(rdata === exp_rd, "R11", "rdata", 32'(rdata), 32'(exp_rd));
    end
  end

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req   = 1'b1;
    wr    = w;
    addr  = a;
    wdata = d;
    @(negedge clk);
    req   = 1'b0;
  endtask

  task automatic wait_idle();
    while (!ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      model_mem[i] = DW'(i) ^ 8'h5A;
      phys_mem[i]  = DW'(i) ^ 8'h5A;
    end
    rst_n = 1'b0; pwr_good = 1'b1; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the pins
    chk({sram_ce_n, sram_oe_n, sram_we_n} === 3'b111, "R1", "strobes in reset",
        32'({sram_ce_n, sram_oe_n, sram_we_n}), 32'd7);
    chk(sram_dq_oe === 1'b0, "R1", "dq_oe in reset", 32'(sram_dq_oe), 32'd0);
    chk(ready === 1'b1 && rvalid === 1'b0 && err === 1'b0, "R1", "ready/rvalid/err in reset",
        32'({ready, rvalid, err}), 32'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_checks = 1;

    // R3 R11: writes at both ends of the array and in the middle
    issue(1, 11'd0, 8'h11);    wait_idle();
    issue(1, 11'd2047, 8'hEE); wait_idle();
    issue(1, 11'd5, 8'h3C);    wait_idle();
    // R2 R11: read-back, back to back
    issue(0, 11'd0, 8'h00);    wait_idle();
    issue(0, 11'd2047, 8'h00); wait_idle();
    issue(0, 11'd5, 8'h00);    wait_idle();
    issue(0, 11'd100, 8'h00);  wait_idle();
    // Read issued in the same cycle the previous read reports
    issue(0, 11'd5, 8'h00);
    while (!ready) @(negedge clk);
    issue(0, 11'd0, 8'h00);    wait_idle();

    // R10: request while busy is ignored
    issue(1, 11'd7, 8'hC3);
    @(negedge clk); req = 1'b1; wr = 1'b1; addr = 11'd8; wdata = 8'h81;
    @(negedge clk); req = 1'b0;
    wait_idle();
    issue(0, 11'd8, 8'h00); wait_idle();
    issue(0, 11'd7, 8'h00); wait_idle();

    // R7: lockout in idle
    pwr_good = 1'b0;
    repeat (2) @(negedge clk);
    issue(1, 11'd9, 8'h99);
    repeat (2) @(negedge clk);
    issue(0, 11'd9, 8'h00);
    repeat (2) @(negedge clk);
    pwr_good = 1'b1;
    @(negedge clk);
    issue(0, 11'd9, 8'h00); wait_idle();

    // R8: drop during read access
    issue(0, 11'd12, 8'h00);
    pwr_good = 1'b0;
    @(negedge clk); pwr_good = 1'b1;
    wait_idle();
    // R8: drop during write setup
    issue(1, 11'd13, 8'h77);
    pwr_good = 1'b0;
    @(negedge clk); pwr_good = 1'b1;
    wait_idle();
    issue(0, 11'd13, 8'h00); wait_idle();

    // R9: drop while the write strobe is low
    issue(1, 11'd14, 8'h42);
    @(negedge clk); pwr_good = 1'b0;
    wait_idle();
    pwr_good = 1'b1;
    @(negedge clk);
    issue(0, 11'd14, 8'h00); wait_idle();

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule